// File: doc/BRIEF.md
# Nibble-Packed Instruction Prefetch Unpacker

This block feeds an instruction decoder from a byte-wide instruction memory whose program is packed at nibble granularity. It issues byte reads over a simple request/grant port, gathers the returned bytes in a small byte buffer and cuts them into variable-length instructions. Each instruction is pushed into a four-entry queue that the decoder drains through a valid/ready handshake.

An instruction is one of three sizes: a lone nibble, a full byte, or a full byte followed by an operand byte. Two short instructions may share one byte. A byte-sized opcode may also sit in the second half of a byte, in which case its missing extension nibble reads as zero. Every issued instruction carries the byte address and nibble index where it starts, so the decoder can form relative branch targets.

A jump input discards everything queued or half-consumed in the same cycle and restarts fetch at a byte-aligned target.

Top module: `nibble_prefetch`

## Requirements
- R1: The opcode is the leading nibble of the slot. Opcodes 0000..0111 issue as `out_kind`=0 with `out_ext`=0 and `out_opnd`=0. Opcodes 1000..1101 issue as `out_kind`=1, with `out_opnd`=0. Opcodes 1110 and 1111 issue as `out_kind`=2 with `out_opnd` taken from the following byte. For a byte-sized opcode in the high slot, `out_ext` is the low nibble of the same byte.
- R2: Within a byte, the high nibble (bits 7:4) is issued before the low nibble (bits 3:0). `out_nib` is 0 for the high slot and 1 for the low slot.
- R3: A byte-sized opcode found in the low slot is issued with `out_ext`=0000. If it takes an operand, the next byte supplies `out_opnd`. Decoding then resumes at the high slot of the byte after the last one used.
- R4: A byte equal to 0xFF in the high slot is not issued as an instruction. It appears as `out_kind`=3 with `out_op`=1111, `out_ext`=1111 and `out_opnd`=0, consumes only that byte, and is followed by the high slot of the next byte.
- R5: Every issued entry reports in `out_addr` the byte address where its opcode nibble lies, and in `out_nib` which slot of that byte holds it.
- R6: A cycle with `jump_valid` high empties the queue and drops any partly used byte or returning read, so `out_valid` is low in the next cycle. The next instruction issued is the high slot of the byte at `jump_addr`.
- R7: With `out_ready` held low, `out_valid` and all output fields hold steady. Once the four-entry queue and the byte buffer are full, `mem_req` falls to 0. Across stalls of either side, no instruction is lost or repeated.
- R8: A read is accepted on a cycle with `mem_req` and `mem_gnt` both high, and its data is presented with `mem_rvalid` one cycle later. `mem_addr` steps by one per accepted read, holds while the grant is low, and wraps from 0xFFF to 0x000.
- R9: During reset `out_valid` is 0. In the first cycle after reset, fetch requests address 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 12 | Byte address of the request |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 8 | Returned instruction byte |
| mem_rvalid | input | 1 | `mem_rdata` valid, one cycle after a grant |
| jump_valid | input | 1 | Redirect fetch and flush |
| jump_addr | input | 12 | Byte-aligned redirect target |
| out_valid | output | 1 | Queue head holds an instruction |
| out_ready | input | 1 | Decoder takes the head this cycle |
| out_op | output | 4 | Opcode nibble |
| out_ext | output | 4 | Extension nibble |
| out_opnd | output | 8 | Operand byte |
| out_kind | output | 2 | 0 nibble, 1 byte, 2 byte plus operand, 3 reserved escape |
| out_addr | output | 12 | Byte address of the instruction start |
| out_nib | output | 1 | Slot of the start: 0 high, 1 low |

## Verification
The hardest state to reach is a redirect that lands on the same clock edge as a granted read. That read's byte then comes back after the flush and must be thrown away. The same applies when the redirect catches a low-slot opcode that is still waiting for its operand byte. The stimulus reaches these states by sweeping the number of instructions consumed before each jump and by cycling several grant and ready duty patterns, so jumps fall on many different fetch phases. Every instruction that follows is compared field by field against a reference walk of the program image.

// File: rtl/nibpf_pkg.sv
// Shared definitions for the nibble-packed prefetch unpacker.
// Assumes a 12-bit byte address space for instruction memory.
package nibpf_pkg;

    localparam int unsigned PF_AW = 12;

    // Size class of an issued entry.
    typedef enum logic [1:0] {
        KIND_NIB  = 2'd0,
        KIND_BYTE = 2'd1,
        KIND_OPND = 2'd2,
        KIND_RSVD = 2'd3
    } kind_e;

    // One unpacked instruction as held in the issue queue.
    typedef struct packed {
        logic [PF_AW-1:0] addr;
        logic             nib;
        kind_e            kind;
        logic [3:0]       op;
        logic [3:0]       ext;
        logic [7:0]       opnd;
    } insn_t;

endpackage

// File: rtl/pf_fetch.sv
// Fetch address generator. It issues byte reads while the byte buffer,
// counting the one read that may still be in flight, has room.
// Assumes read data returns exactly one cycle after the grant.
// A flush drops the read accepted in the flush cycle.
module pf_fetch
    import nibpf_pkg::*;
#(
    parameter  int BQ_DEPTH = 4,
    localparam int CW       = $clog2(BQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PF_AW-1:0] flush_addr,
    input  logic [CW-1:0]    bq_cnt,
    input  logic             gnt,
    input  logic             rvalid,
    output logic             req,
    output logic [PF_AW-1:0] addr,
    output logic             wr
);

    logic [PF_AW-1:0] fa_q;
    logic             pend_q;

    // Request only while the buffer can take the byte plus any in flight.
    always_comb req = (int'(bq_cnt) + int'(pend_q)) < BQ_DEPTH;

    // A returning byte is kept only if its read was not flushed.
    always_comb wr = rvalid && pend_q && !flush;

    assign addr = fa_q;

    // Address counter and in-flight flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fa_q   <= '0;
            pend_q <= 1'b0;
        end else if (flush) begin
            fa_q   <= flush_addr;
            pend_q <= 1'b0;
        end else begin
            pend_q <= req && gnt;
            if (req && gnt) fa_q <= fa_q + 1'b1;
        end
    end

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt && !flush) |=> (addr == $past(addr)));

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && gnt && !flush) |=> (addr == $past(addr) + 1'b1));

    // R6
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (addr == $past(flush_addr) && !wr));

endmodule

// File: rtl/pf_bytebuf.sv
// Byte buffer between fetch and the unpacker. It accepts one byte per
// cycle, exposes the two oldest bytes, and retires zero, one or two per
// cycle. Assumes the writer never exceeds the free space.
module pf_bytebuf #(
    parameter  int DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr,
    input  logic [7:0]    wdata,
    input  logic [1:0]    pop_n,
    output logic [7:0]    b0,
    output logic [7:0]    b1,
    output logic [CW-1:0] cnt
);

    logic [7:0]    data_q [DEPTH];
    logic [PW-1:0] rp_q, wp_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign b0  = data_q[rp_q];
    assign b1  = data_q[nxt(rp_q)];
    assign cnt = cnt_q;

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr) data_q[wp_q] <= wdata;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr) wp_q <= nxt(wp_q);
            case (pop_n)
                2'd1:    rp_q <= nxt(rp_q);
                2'd2:    rp_q <= nxt(nxt(rp_q));
                default: rp_q <= rp_q;
            endcase
            cnt_q <= cnt_q + CW'(wr) - CW'(pop_n);
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (int'(cnt_q) < DEPTH || pop_n != 2'd0));

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pop_n) <= int'(cnt_q));

endmodule

// File: rtl/pf_split.sv
// Unpacker. It tracks the byte address and nibble slot at the head of the
// byte buffer and cuts one instruction per cycle from it. Assumes the
// buffer head byte always sits at the tracked address.
module pf_split
    import nibpf_pkg::*;
#(
    parameter  int BQ_DEPTH = 4,
    localparam int CW       = $clog2(BQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PF_AW-1:0] flush_addr,
    input  logic [7:0]       b0,
    input  logic [7:0]       b1,
    input  logic [CW-1:0]    bcnt,
    input  logic             iq_full,
    output logic [1:0]       pop_n,
    output logic             push,
    output insn_t            insn
);

    logic [PF_AW-1:0] addr_q;
    logic             nib_q;
    logic [3:0]       slot_op;
    kind_e            kind;
    logic             is_rsvd;

    // Classify the opcode in the current slot.
    always_comb begin
        slot_op = nib_q ? b0[3:0] : b0[7:4];
        is_rsvd = !nib_q && (b0 == 8'hFF);
        if (is_rsvd)             kind = KIND_RSVD;
        else if (!slot_op[3])    kind = KIND_NIB;
        else if (slot_op < 4'hE) kind = KIND_BYTE;
        else                     kind = KIND_OPND;
    end

    // Issue when enough bytes are buffered and the queue has room.
    always_comb begin
        push = (bcnt != '0) && !iq_full && !flush &&
               (kind != KIND_OPND || int'(bcnt) >= 2);
        pop_n = 2'd0;
        if (push) begin
            case (kind)
                KIND_NIB:  pop_n = nib_q ? 2'd1 : 2'd0;
                KIND_OPND: pop_n = 2'd2;
                default:   pop_n = 2'd1;
            endcase
        end
    end

    // Assemble the queue entry.
    always_comb begin
        insn.addr = addr_q;
        insn.nib  = nib_q;
        insn.kind = kind;
        insn.op   = slot_op;
        if (is_rsvd)                        insn.ext = 4'hF;
        else if (nib_q || kind == KIND_NIB) insn.ext = 4'h0;
        else                                insn.ext = b0[3:0];
        insn.opnd = (kind == KIND_OPND) ? b1 : 8'h00;
    end

    // Head position: byte address and slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            nib_q  <= 1'b0;
        end else if (flush) begin
            addr_q <= flush_addr;
            nib_q  <= 1'b0;
        end else if (push) begin
            nib_q  <= (kind == KIND_NIB) && !nib_q;
            addr_q <= addr_q + {{(PF_AW-2){1'b0}}, pop_n};
        end
    end

    // R2
    hi_then_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && insn.kind == KIND_NIB && !insn.nib) |=>
        (insn.nib && insn.addr == $past(insn.addr)));

endmodule

// File: rtl/pf_iqueue.sv
// Issue queue of unpacked instructions toward the decoder, with a
// valid/ready head. Assumes the writer pushes only when not full.
module pf_iqueue
    import nibpf_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  push,
    input  insn_t din,
    input  logic  ready,
    output logic  valid,
    output logic  full,
    output insn_t head
);

    logic [PW-1:0] rp_q, wp_q;
    logic [CW-1:0] cnt_q;
    logic          pop;
    insn_t         slots [DEPTH];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign valid = (cnt_q != '0);
    assign full  = (int'(cnt_q) == DEPTH);
    assign pop   = valid && ready && !flush;
    assign head  = slots[rp_q];

    // One storage slot per queue entry.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        insn_t slot_q;
        always_ff @(posedge clk) begin
            if (push && wp_q == PW'(gi)) slot_q <= din;
        end
        assign slots[gi] = slot_q;
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= nxt(wp_q);
            if (pop)  rp_q <= nxt(rp_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    // R7
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready && !flush) |=> (valid && head == $past(head)));

    // R7
    iq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

endmodule

// File: rtl/nibble_prefetch.sv
// Top of the nibble-packed prefetch unpacker: fetch, byte buffer,
// unpacker and issue queue. Assumes one-cycle read latency and
// byte-aligned jump targets.
module nibble_prefetch
    import nibpf_pkg::*;
#(
    parameter int IQ_DEPTH = 4,
    parameter int BQ_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        mem_req,
    output logic [11:0] mem_addr,
    input  logic        mem_gnt,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_rvalid,
    input  logic        jump_valid,
    input  logic [11:0] jump_addr,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [3:0]  out_op,
    output logic [3:0]  out_ext,
    output logic [7:0]  out_opnd,
    output logic [1:0]  out_kind,
    output logic [11:0] out_addr,
    output logic        out_nib
);

    localparam int BCW = $clog2(BQ_DEPTH + 1);

    logic [BCW-1:0] bq_cnt;
    logic           bq_wr;
    logic [7:0]     bq_b0, bq_b1;
    logic [1:0]     bq_pop;
    logic           iq_push, iq_full;
    insn_t          iq_din, iq_head;

    pf_fetch #(.BQ_DEPTH(BQ_DEPTH)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (jump_valid),
        .flush_addr (jump_addr),
        .bq_cnt     (bq_cnt),
        .gnt        (mem_gnt),
        .rvalid     (mem_rvalid),
        .req        (mem_req),
        .addr       (mem_addr),
        .wr         (bq_wr)
    );

    pf_bytebuf #(.DEPTH(BQ_DEPTH)) u_bytes (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (jump_valid),
        .wr    (bq_wr),
        .wdata (mem_rdata),
        .pop_n (bq_pop),
        .b0    (bq_b0),
        .b1    (bq_b1),
        .cnt   (bq_cnt)
    );

    pf_split #(.BQ_DEPTH(BQ_DEPTH)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (jump_valid),
        .flush_addr (jump_addr),
        .b0         (bq_b0),
        .b1         (bq_b1),
        .bcnt       (bq_cnt),
        .iq_full    (iq_full),
        .pop_n      (bq_pop),
        .push       (iq_push),
        .insn       (iq_din)
    );

    pf_iqueue #(.DEPTH(IQ_DEPTH)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (jump_valid),
        .push  (iq_push),
        .din   (iq_din),
        .ready (out_ready),
        .valid (out_valid),
        .full  (iq_full),
        .head  (iq_head)
    );

    assign out_op   = iq_head.op;
    assign out_ext  = iq_head.ext;
    assign out_opnd = iq_head.opnd;
    assign out_kind = iq_head.kind;
    assign out_addr = iq_head.addr;
    assign out_nib  = iq_head.nib;

    // R6
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_valid |=> !out_valid);

    // R4
    rsvd_hi_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == KIND_RSVD) |-> (!out_nib && out_opnd == 8'h00));

    // R3
    lo_slot_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nib && out_kind != KIND_NIB) |-> (out_ext == 4'h0));

endmodule

// File: tb/sim_nibble_prefetch.sv
// Bench: walks a program image in a reference model and compares every
// issued instruction under varied grant/ready duty cycles and jumps.
module sim_nibble_prefetch;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [11:0] mem_addr;
    logic        mem_gnt = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        mem_rvalid = 1'b0;
    logic        jump_valid = 1'b0;
    logic [11:0] jump_addr = 12'h000;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_op, out_ext;
    logic [7:0]  out_opnd;
    logic [1:0]  out_kind;
    logic [11:0] out_addr;
    logic        out_nib;

    logic [7:0]  mem [4096];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;
    bit          done    = 0;
    logic [11:0] ref_a;
    logic        ref_n;

    nibble_prefetch u0 (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .jump_valid(jump_valid), .jump_addr(jump_addr), .out_valid(out_valid),
        .out_ready(out_ready), .out_op(out_op), .out_ext(out_ext),
        .out_opnd(out_opnd), .out_kind(out_kind), .out_addr(out_addr),
        .out_nib(out_nib)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Memory model: data one cycle after a granted request (R8).
    always @(posedge clk) begin
        mem_rvalid <= mem_req && mem_gnt && rst_n;
        mem_rdata  <= mem[mem_addr];
        cyc        <= cyc + 1;
    end

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (R7): actual=%0d cycles expected=completion", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string what);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", what);
        end
    endtask

    // Reference decode of the entry starting at (a, n) and the next position.
    task automatic peek(input logic [11:0] a, input logic n,
                        output logic [3:0] op, output logic [3:0] ext,
                        output logic [7:0] od, output logic [1:0] kd,
                        output logic [11:0] na, output logic nn);
        logic [7:0] b0, b1;
        b0  = mem[a];
        b1  = mem[a + 12'd1];
        op  = n ? b0[3:0] : b0[7:4];
        ext = 4'h0;
        od  = 8'h00;
        nn  = 1'b0;
        na  = a + 12'd1;
        if (!n && b0 == 8'hFF) begin
            kd  = 2'd3;
            ext = 4'hF;                  // R4
        end else if (op < 4'd8) begin
            kd = 2'd0;                   // R1, R2
            if (!n) begin nn = 1'b1; na = a; end
        end else if (op < 4'd14) begin
            kd = 2'd1;
            if (!n) ext = b0[3:0];       // R1 / R3 low slot keeps 0
        end else begin
            kd = 2'd2;
            if (!n) ext = b0[3:0];
            od = b1;
            na = a + 12'd2;              // R3
        end
    endtask

    // Compare the head against the reference; optionally advance.
    task automatic check_head(input bit advance, input string extra);
        logic [3:0]  op, ext;
        logic [7:0]  od;
        logic [1:0]  kd;
        logic [11:0] na;
        logic        nn;
        string       tag;
        peek(ref_a, ref_n, op, ext, od, kd, na, nn);
        if (kd == 2'd3)               tag = "R4";
        else if (ref_n && kd != 2'd0) tag = "R3";
        else if (kd == 2'd0)          tag = "R2";
        else                          tag = "R1";
        chk(out_valid && out_op == op && out_ext == ext && out_opnd == od &&
            out_kind == kd && out_addr == ref_a && out_nib == ref_n,
            $sformatf("%s/R5%s: actual v=%0b op=%h ext=%h od=%h k=%0d a=%h n=%0b expected v=1 op=%h ext=%h od=%h k=%0d a=%h n=%0b",
                      tag, extra, out_valid, out_op, out_ext, out_opnd, out_kind,
                      out_addr, out_nib, op, ext, od, kd, ref_a, ref_n));
        if (advance) begin
            ref_a = na;
            ref_n = nn;
        end
    endtask

    // Consume n instructions with periodic ready/grant gaps (0 = always on).
    task automatic run(input int n, input int rper, input int gper);
        int got;
        got = 0;
        while (got < n && !done) begin
            @(negedge clk);
            out_ready = (rper == 0) || ((cyc % rper) != 0);
            mem_gnt   = (gper == 0) || ((cyc % gper) != 0);
            #1;
            if (out_valid && out_ready) begin
                check_head(1'b1, "");
                got++;
            end
        end
    endtask

    task automatic jump_to(input logic [11:0] t);
        @(negedge clk);
        out_ready  = 1'b0;
        jump_valid = 1'b1;
        jump_addr  = t;
        @(negedge clk);
        jump_valid = 1'b0;
        #1;
        // R6: queue emptied by the redirect
        chk(!out_valid, $sformatf("R6 flush: actual out_valid=%0b expected 0", out_valid));
        ref_a = t;
        ref_n = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++)
            mem[i] = (i < 256) ? 8'(i) : 8'((i * 73) ^ (i >> 3));
        // Crafted region: low-slot operand opcode, reserved bytes, low-slot byte opcode.
        mem[12'h800] = 8'h1F; mem[12'h801] = 8'h5A; mem[12'h802] = 8'hFF;
        mem[12'h803] = 8'h39; mem[12'h804] = 8'h2E; mem[12'h805] = 8'hC3;
        mem[12'h806] = 8'hFF; mem[12'h807] = 8'hE0; mem[12'h808] = 8'h77;
        mem[12'h809] = 8'h4F; mem[12'h80A] = 8'hFF; mem[12'h80B] = 8'h6D;

        // R9: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, $sformatf("R9 reset: actual out_valid=%0b expected 0", out_valid));
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(mem_req && mem_addr == 12'h000,
            $sformatf("R9 first fetch: actual req=%0b addr=%h expected req=1 addr=000", mem_req, mem_addr));
        ref_a = 12'h000;
        ref_n = 1'b0;

        // R1 R2 R3 R4 R5: long walk over every byte value, mixed stalls
        run(900, 5, 7);
        run(400, 0, 0);
        run(300, 3, 2);

        // R7: decoder stalled, buffers fill, fetch stops, head holds
        @(negedge clk);
        out_ready = 1'b0;
        mem_gnt   = 1'b1;
        repeat (40) @(negedge clk);
        #1;
        chk(!mem_req, $sformatf("R7 fetch stop: actual mem_req=%0b expected 0", mem_req));
        check_head(1'b0, " R7 held head");
        run(200, 0, 0);

        // R8: grant low holds the address, one grant steps it
        @(negedge clk);
        mem_gnt = 1'b0;
        jump_to(12'h400);
        repeat (4) @(negedge clk);
        #1;
        chk(mem_req && mem_addr == 12'h400,
            $sformatf("R8 hold: actual req=%0b addr=%h expected req=1 addr=400", mem_req, mem_addr));
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        #1;
        chk(mem_addr == 12'h401, $sformatf("R8 step: actual addr=%h expected 401", mem_addr));
        run(40, 0, 3);

        // R6: jumps at many fetch phases, often mid-byte
        for (int k = 0; k < 30; k++) begin
            logic [11:0] t;
            int rp, gp;
            rp = (k % 3 == 0) ? 0 : (k % 3) + 1;
            gp = (k % 4 == 0) ? 0 : (k % 4) + 1;
            if (k == 0 || k == 7)      t = 12'h800;
            else if (k == 1 || k == 9) t = 12'hFFD;
            else                       t = 12'((k * 389 + 12'h123) & 12'hFFF);
            run((k % 5) + 1, rp, gp);
            mem_gnt = k[0];
            jump_to(t);
            run(12 + (k % 7), rp, gp);
        end

        // R8: wrap from the top of the address space
        jump_to(12'hFFE);
        run(40, 2, 0);

        summary();
    end

endmodule